// File: doc/BRIEF.md
# Remote Reconfiguration Register Bank

This block holds the registers that user logic uses to steer which image a reconfigurable device loads next. Four registers make up the bank. A serial shift register is the only access path for user logic. An update register holds the staged next-boot settings. A control register holds the settings that are currently in force. A status register records why the last reconfiguration happened. The shift and update registers run on a user clock. The control and status registers run on a slow internal-oscillator clock.

A strap input tells the bank whether the running image is the factory image or an application image. This strap decides where reads come from and whether the update register may be written. A second strap selects serial-flash or parallel-flash booting, and that choice sets the reset boot address. In parallel-flash mode a separately supplied boot address can replace the built-in default.

Requests that need the oscillator domain are a reconfiguration trigger and a status capture. Each one crosses over on a toggle handshake, and `busy` stays high until the oscillator side has acknowledged it.

Top module: `reconf_regbank`

## Requirements
- R1: While `shift_en` is high and no request or capture result is being taken in that cycle, the shift register moves one place toward bit 0 on each user-clock edge. `sdin` enters at bit 38 and `sdout` always shows bit 0, so a word is shifted in and out least significant bit first.
- R2: `upd_req` copies the shift register into the update register only while `factory_mode` is 1. When `factory_mode` is 0 the update register is never written.
- R3: `rd_req` loads the shift register with the control word when `factory_mode` is 0, and with the update word when `factory_mode` is 1.
- R4: `cap_req` starts a handshake. When `busy` falls, the shift register holds the status code in bits [4:0] and zeros in all higher bits.
- R5: `trig_req` starts a handshake. By the time `busy` falls, the control word equals the update word and `reconf_status` holds the recorded cause. The control word changes at no other time after reset.
- R6: During reset the control word and the update word take a default value. The address bits are 24'h000000 when `pflash_boot` is 0. When `pflash_boot` is 1 they are 24'h010000, or `boot_ovr_addr` if `boot_ovr_en` is 1. All other fields reset to 0, the status resets to 0 and `busy` resets to 0.
- R7: `busy` rises on the user-clock edge that accepts a trigger or a capture. While `busy` is high, every request input is ignored.
- R8: The control word is presented on the output ports as follows. `cfg_addr` carries bits [23:0]. `wdt_timeout` carries bits [35:24]. `wdt_enable` carries bit 36. `early_done_chk` carries bit 37. `osc_select` carries bit 38.
- R9: When several requests arrive in the same cycle, only one is taken, in this order: trigger, then capture, then update, then read. An `upd_req` that is present always blocks a read in that cycle, even when it is itself refused.
- R10: The cause codes are one-hot. Bit 0 is a configuration CRC error. Bit 1 is an external status-pin assertion. Bit 2 is a core-logic request. Bit 3 is a watchdog timeout. Bit 4 is a configuration-pin request. If `trig_cause` has more than one bit set, only its lowest set bit is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| uclk | input | 1 | User clock for the shift and update registers |
| oclk | input | 1 | Oscillator clock for the control and status registers |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| factory_mode | input | 1 | 1 = factory image running, 0 = application image running |
| pflash_boot | input | 1 | 1 = parallel-flash boot, 0 = serial-flash boot |
| boot_ovr_en | input | 1 | Use `boot_ovr_addr` as the parallel-flash default address |
| boot_ovr_addr | input | 24 | Replacement default boot address |
| shift_en | input | 1 | Shift one bit per user clock |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out (shift register bit 0) |
| rd_req | input | 1 | Load control or update word into the shift register |
| upd_req | input | 1 | Write the shift register into the update register |
| cap_req | input | 1 | Capture the status into the shift register |
| trig_req | input | 1 | Trigger a reconfiguration |
| trig_cause | input | 5 | Cause code for the trigger |
| busy | output | 1 | Handshake in progress |
| cfg_addr | output | 24 | Control word boot address |
| wdt_timeout | output | 12 | Control word watchdog timeout |
| wdt_enable | output | 1 | Control word watchdog enable |
| early_done_chk | output | 1 | Control word early configuration-done check |
| osc_select | output | 1 | Control word internal-oscillator startup clock select |
| reconf_status | output | 5 | Recorded reconfiguration cause |

## Verification
On every cycle the assertions check four things. No request is accepted while `busy` is high, and an accepted trigger or capture raises `busy`. An application image never changes the update word. The control word moves only on an oscillator-side trigger event, and the status stays one-hot. They also check that shifted data enters at the top bit and that a capture result lands as a zero-extended status. Only the bench scenarios can show the end-to-end contents: the values that come back through the serial path, the mode-dependent read source, the reset addresses for each boot scheme and override, request priority, and the reduction of a multi-bit cause to its lowest bit.

// File: rtl/rrb_pkg.sv
package rrb_pkg;
  parameter int ADDR_W  = 24;
  parameter int WDT_W   = 12;
  parameter int CAUSE_W = 5;

  localparam int WORD_W    = ADDR_W + WDT_W + 3;
  localparam int WDT_EN_B  = ADDR_W + WDT_W;
  localparam int EARLY_B   = WDT_EN_B + 1;
  localparam int OSC_SEL_B = WDT_EN_B + 2;

  localparam logic [ADDR_W-1:0] PAR_DEFAULT_ADDR = ADDR_W'(32'h0001_0000);

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  typedef enum logic {REQ_TRIG = 1'b0, REQ_CAP = 1'b1} req_kind_e;

  // Reset value of control and update words for the selected boot scheme.
  function automatic word_t default_word(input logic pflash, input logic ovr_en,
                                         input logic [ADDR_W-1:0] ovr);
    word_t w;
    w = '0;
    if (pflash) w[ADDR_W-1:0] = ovr_en ? ovr : PAR_DEFAULT_ADDR;
    return w;
  endfunction

  // One shift step: new bit at the top, oldest bit falls out of bit 0.
  function automatic word_t shift_step(input word_t cur, input logic din);
    return {din, cur[WORD_W-1:1]};
  endfunction

  // Keep only the lowest set bit of a cause vector.
  function automatic cause_t pick_cause(input cause_t c);
    return c & (~c + CAUSE_W'(1));
  endfunction

  function automatic word_t widen_status(input cause_t c);
    return word_t'(c);
  endfunction
endpackage

// File: rtl/rrb_sync.sv
module rrb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/rrb_user_side.sv
module rrb_user_side
  import rrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              uclk,
  input  logic              rst_n,
  input  logic              factory_mode,
  input  logic              pflash_boot,
  input  logic              boot_ovr_en,
  input  logic [ADDR_W-1:0] boot_ovr_addr,
  input  logic              shift_en,
  input  logic              sdin,
  input  logic              rd_req,
  input  logic              upd_req,
  input  logic              cap_req,
  input  logic              trig_req,
  input  cause_t            trig_cause,
  input  word_t             ctrl_q,
  input  cause_t            status_q,
  input  logic              ack_tgl,
  output logic              sdout,
  output logic              busy,
  output logic              req_tgl,
  output req_kind_e         req_kind,
  output cause_t            cause_q,
  output word_t             upd_q,
  output word_t             sr_q,
  output logic              trig_go,
  output logic              cap_go,
  output logic              upd_go,
  output logic              rd_go,
  output logic              cap_land
);
  logic ack_s, ack_seen, ack_arrive;

  rrb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(uclk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  assign ack_arrive = busy && (ack_s != ack_seen);
  assign trig_go    = !busy && trig_req;
  assign cap_go     = !busy && !trig_req && cap_req;
  assign upd_go     = !busy && !trig_req && !cap_req && upd_req && factory_mode;
  assign rd_go      = !busy && !trig_req && !cap_req && !upd_req && rd_req;
  assign cap_land   = ack_arrive && (req_kind == REQ_CAP);

  always_ff @(posedge uclk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ack_seen <= 1'b0;
      req_tgl  <= 1'b0;
      req_kind <= REQ_TRIG;
      cause_q  <= '0;
    end else if (ack_arrive) begin
      busy     <= 1'b0;
      ack_seen <= ack_s;
    end else if (trig_go || cap_go) begin
      busy     <= 1'b1;
      req_tgl  <= ~req_tgl;
      req_kind <= cap_go ? REQ_CAP : REQ_TRIG;
      if (trig_go) cause_q <= pick_cause(trig_cause);
    end
  end

  always_ff @(posedge uclk or negedge rst_n) begin
    if (!rst_n)      upd_q <= default_word(pflash_boot, boot_ovr_en, boot_ovr_addr);
    else if (upd_go) upd_q <= sr_q;
  end

  always_ff @(posedge uclk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else if (cap_land)
      sr_q <= widen_status(status_q);
    else if (rd_go)
      sr_q <= factory_mode ? upd_q : ctrl_q;
    else if (shift_en && !trig_go && !cap_go && !upd_go)
      sr_q <= shift_step(sr_q, sdin);
  end

  assign sdout = sr_q[0];
endmodule

// File: rtl/rrb_osc_side.sv
module rrb_osc_side
  import rrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              oclk,
  input  logic              rst_n,
  input  logic              pflash_boot,
  input  logic              boot_ovr_en,
  input  logic [ADDR_W-1:0] boot_ovr_addr,
  input  logic              req_tgl,
  input  req_kind_e         req_kind,
  input  cause_t            cause_q,
  input  word_t             upd_q,
  output word_t             ctrl_q,
  output cause_t            status_q,
  output logic              ack_tgl,
  output logic              osc_fire
);
  logic req_s, req_seen;

  rrb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(oclk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign osc_fire = (req_s != req_seen) && (req_kind == REQ_TRIG);

  always_ff @(posedge oclk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      ack_tgl  <= 1'b0;
    end else if (req_s != req_seen) begin
      req_seen <= req_s;
      ack_tgl  <= ~ack_tgl;
    end
  end

  always_ff @(posedge oclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= default_word(pflash_boot, boot_ovr_en, boot_ovr_addr);
      status_q <= '0;
    end else if (osc_fire) begin
      ctrl_q   <= upd_q;
      status_q <= cause_q;
    end
  end
endmodule

// File: rtl/reconf_regbank.sv
module reconf_regbank
  import rrb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              uclk,
  input  logic              oclk,
  input  logic              rst_n,
  input  logic              factory_mode,
  input  logic              pflash_boot,
  input  logic              boot_ovr_en,
  input  logic [ADDR_W-1:0] boot_ovr_addr,
  input  logic              shift_en,
  input  logic              sdin,
  output logic              sdout,
  input  logic              rd_req,
  input  logic              upd_req,
  input  logic              cap_req,
  input  logic              trig_req,
  input  logic [CAUSE_W-1:0] trig_cause,
  output logic              busy,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [WDT_W-1:0]  wdt_timeout,
  output logic              wdt_enable,
  output logic              early_done_chk,
  output logic              osc_select,
  output logic [CAUSE_W-1:0] reconf_status
);
  word_t     sr_q, upd_q, ctrl_q;
  cause_t    status_q, cause_q;
  req_kind_e req_kind;
  logic      req_tgl, ack_tgl, osc_fire;
  logic      trig_go, cap_go, upd_go, rd_go, cap_land;

  rrb_user_side #(.SYNC_STAGES(SYNC_STAGES)) u_user (
    .uclk(uclk), .rst_n(rst_n), .factory_mode(factory_mode),
    .pflash_boot(pflash_boot), .boot_ovr_en(boot_ovr_en), .boot_ovr_addr(boot_ovr_addr),
    .shift_en(shift_en), .sdin(sdin), .rd_req(rd_req), .upd_req(upd_req),
    .cap_req(cap_req), .trig_req(trig_req), .trig_cause(trig_cause),
    .ctrl_q(ctrl_q), .status_q(status_q), .ack_tgl(ack_tgl),
    .sdout(sdout), .busy(busy), .req_tgl(req_tgl), .req_kind(req_kind),
    .cause_q(cause_q), .upd_q(upd_q), .sr_q(sr_q),
    .trig_go(trig_go), .cap_go(cap_go), .upd_go(upd_go), .rd_go(rd_go),
    .cap_land(cap_land)
  );

  rrb_osc_side #(.SYNC_STAGES(SYNC_STAGES)) u_osc (
    .oclk(oclk), .rst_n(rst_n), .pflash_boot(pflash_boot),
    .boot_ovr_en(boot_ovr_en), .boot_ovr_addr(boot_ovr_addr),
    .req_tgl(req_tgl), .req_kind(req_kind), .cause_q(cause_q), .upd_q(upd_q),
    .ctrl_q(ctrl_q), .status_q(status_q), .ack_tgl(ack_tgl), .osc_fire(osc_fire)
  );

  assign cfg_addr       = ctrl_q[ADDR_W-1:0];
  assign wdt_timeout    = ctrl_q[WDT_EN_B-1:ADDR_W];
  assign wdt_enable     = ctrl_q[WDT_EN_B];
  assign early_done_chk = ctrl_q[EARLY_B];
  assign osc_select     = ctrl_q[OSC_SEL_B];
  assign reconf_status  = status_q;
endmodule

// File: rtl/rrb_checker.sv
module rrb_checker
  import rrb_pkg::*;
(
  input logic   uclk,
  input logic   oclk,
  input logic   rst_n,
  input logic   factory_mode,
  input logic   shift_en,
  input logic   sdin,
  input logic   busy,
  input logic   trig_go,
  input logic   cap_go,
  input logic   upd_go,
  input logic   rd_go,
  input logic   cap_land,
  input logic   osc_fire,
  input word_t  sr_q,
  input word_t  upd_q,
  input word_t  ctrl_q,
  input cause_t status_q
);
  a_r7_no_accept_while_busy: assert property (@(posedge uclk) disable iff (!rst_n)
    busy |-> !(trig_go || cap_go || upd_go || rd_go));

  a_r7_request_raises_busy: assert property (@(posedge uclk) disable iff (!rst_n)
    (trig_go || cap_go) |=> busy);

  a_r2_app_update_frozen: assert property (@(posedge uclk) disable iff (!rst_n)
    !factory_mode |=> $stable(upd_q));

  a_r1_top_bit_entry: assert property (@(posedge uclk) disable iff (!rst_n)
    (shift_en && !cap_land && !trig_go && !cap_go && !upd_go && !rd_go)
      |=> (sr_q[WORD_W-1] == $past(sdin)));

  a_r4_capture_zero_ext: assert property (@(posedge uclk) disable iff (!rst_n)
    cap_land |=> (sr_q == widen_status($past(status_q))));

  a_r5_ctrl_moves_on_fire_only: assert property (@(posedge oclk) disable iff (!rst_n)
    !osc_fire |=> $stable(ctrl_q));

  a_r10_status_onehot: assert property (@(posedge oclk) disable iff (!rst_n)
    $onehot0(status_q));
endmodule

bind reconf_regbank rrb_checker u_chk (
  .uclk(uclk), .oclk(oclk), .rst_n(rst_n), .factory_mode(factory_mode),
  .shift_en(shift_en), .sdin(sdin), .busy(busy),
  .trig_go(trig_go), .cap_go(cap_go), .upd_go(upd_go), .rd_go(rd_go),
  .cap_land(cap_land), .osc_fire(osc_fire),
  .sr_q(sr_q), .upd_q(upd_q), .ctrl_q(ctrl_q), .status_q(status_q)
);

// File: tb/sim_reconf_regbank.sv
module sim_reconf_regbank;
  localparam int W  = 39;
  localparam int VW = 1 + W + 5;
  localparam int NV = 6;

  // {factory_mode, word, cause}
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b1, 39'h12_3456_789A, 5'b00001},
    {1'b1, 39'h7F_FFFF_FFFF, 5'b00100},
    {1'b0, 39'h55_5555_5555, 5'b01000},
    {1'b1, 39'h2A_AAAA_AAAA, 5'b10000},
    {1'b0, 39'h00_0000_0001, 5'b00010},
    {1'b1, 39'h40_0F00_C0DE, 5'b01000}
  };

  logic uclk = 1'b0, oclk = 1'b0, rst_n = 1'b0;
  logic factory_mode = 1'b1, pflash_boot = 1'b0, boot_ovr_en = 1'b0;
  logic [23:0] boot_ovr_addr = '0;
  logic shift_en = 1'b0, sdin = 1'b0;
  logic rd_req = 1'b0, upd_req = 1'b0, cap_req = 1'b0, trig_req = 1'b0;
  logic [4:0] trig_cause = '0;
  logic sdout, busy, wdt_enable, early_done_chk, osc_select;
  logic [23:0] cfg_addr;
  logic [11:0] wdt_timeout;
  logic [4:0] reconf_status;

  int nchk = 0, nfail = 0;
  logic [W-1:0] exp_upd, exp_ctrl, got;

  always #2 uclk = ~uclk;
  always #7 oclk = ~oclk;

  reconf_regbank u0 (
    .uclk(uclk), .oclk(oclk), .rst_n(rst_n), .factory_mode(factory_mode),
    .pflash_boot(pflash_boot), .boot_ovr_en(boot_ovr_en), .boot_ovr_addr(boot_ovr_addr),
    .shift_en(shift_en), .sdin(sdin), .sdout(sdout), .rd_req(rd_req),
    .upd_req(upd_req), .cap_req(cap_req), .trig_req(trig_req),
    .trig_cause(trig_cause), .busy(busy), .cfg_addr(cfg_addr),
    .wdt_timeout(wdt_timeout), .wdt_enable(wdt_enable),
    .early_done_chk(early_done_chk), .osc_select(osc_select),
    .reconf_status(reconf_status)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pf, input logic oen, input logic [23:0] oa);
    @(negedge uclk);
    rst_n = 1'b0; pflash_boot = pf; boot_ovr_en = oen; boot_ovr_addr = oa;
    repeat (6) @(negedge uclk);
    rst_n = 1'b1;
    repeat (2) @(negedge uclk);
  endtask

  task automatic do_op(input logic t, input logic c, input logic u, input logic r,
                       input logic [4:0] cause);
    @(negedge uclk);
    trig_req = t; cap_req = c; upd_req = u; rd_req = r; trig_cause = cause;
    @(negedge uclk);
    trig_req = 0; cap_req = 0; upd_req = 0; rd_req = 0; trig_cause = '0;
  endtask

  task automatic wait_idle();
    @(negedge uclk);
    while (busy) @(negedge uclk);
  endtask

  task automatic shift_in(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      @(negedge uclk); shift_en = 1'b1; sdin = w[i];
    end
    @(negedge uclk); shift_en = 1'b0; sdin = 1'b0;
  endtask

  task automatic shift_out(output logic [W-1:0] w);
    for (int i = 0; i < W; i++) begin
      @(negedge uclk); w[i] = sdout; shift_en = 1'b1; sdin = 1'b0;
    end
    @(negedge uclk); shift_en = 1'b0;
  endtask

  task automatic chk_ctrl(input string req, input logic [W-1:0] e);
    chk({req, " addr"},  64'(cfg_addr), 64'(e[23:0]));
    chk({req, " R8 fields"},
        64'({osc_select, early_done_chk, wdt_enable, wdt_timeout}), 64'(e[38:24]));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge uclk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R6: serial-flash reset defaults
    do_reset(1'b0, 1'b0, 24'h0);
    chk("R6 serial addr", 64'(cfg_addr), 64'h0);
    chk("R6 status", 64'(reconf_status), 64'h0);
    chk("R6 busy", 64'(busy), 64'h0);
    chk("R6 sdout", 64'(sdout), 64'h0);
    // R6: parallel-flash default
    do_reset(1'b1, 1'b0, 24'hFFFFFF);
    chk("R6 parallel addr", 64'(cfg_addr), 64'h010000);
    // R6: override address, also check update word via factory read (R3)
    do_reset(1'b1, 1'b1, 24'h3A5C00);
    chk_ctrl("R6 override", {15'h0, 24'h3A5C00});
    do_op(0, 0, 0, 1, '0);
    shift_out(got);
    chk("R6 R3 update default", 64'(got), 64'({15'h0, 24'h3A5C00}));
    exp_upd  = {15'h0, 24'h3A5C00};
    exp_ctrl = exp_upd;

    // Table walk: R1 R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      logic            fac;
      logic [W-1:0]    wd;
      logic [4:0]      cz;
      {fac, wd, cz} = VECS[v];
      @(negedge uclk); factory_mode = fac;
      shift_in(wd);
      do_op(0, 0, 1, 0, '0);
      if (fac) exp_upd = wd;
      do_op(1, 0, 0, 0, cz);
      wait_idle();
      exp_ctrl = exp_upd;
      chk_ctrl("R5 R2 vec ctrl", exp_ctrl);
      chk("R5 R10 vec status", 64'(reconf_status), 64'(cz));
      do_op(0, 0, 0, 1, '0);
      shift_out(got);
      chk("R1 R3 vec readback", 64'(got), 64'(fac ? exp_upd : exp_ctrl));
      do_op(0, 1, 0, 0, '0);
      wait_idle();
      shift_out(got);
      chk("R4 vec capture", 64'(got), 64'(cz));
    end

    // R3: factory read returns staged update, application read returns control
    @(negedge uclk); factory_mode = 1'b1;
    shift_in(39'h0A_BCDE_F012);
    do_op(0, 0, 1, 0, '0);
    exp_upd = 39'h0A_BCDE_F012;
    do_op(0, 0, 0, 1, '0);
    shift_out(got);
    chk("R3 factory read", 64'(got), 64'(exp_upd));
    @(negedge uclk); factory_mode = 1'b0;
    do_op(0, 0, 0, 1, '0);
    shift_out(got);
    chk("R3 app read", 64'(got), 64'(exp_ctrl));
    // R2: application-mode update write refused
    shift_in(39'h33_3333_3333);
    do_op(0, 0, 1, 0, '0);
    @(negedge uclk); factory_mode = 1'b1;
    do_op(0, 0, 0, 1, '0);
    shift_out(got);
    chk("R2 app write blocked", 64'(got), 64'(exp_upd));

    // R9: update beats read in the same cycle
    shift_in(39'h1B_0000_00B1);
    do_op(0, 0, 1, 1, '0);
    exp_upd = 39'h1B_0000_00B1;
    shift_out(got);
    chk("R9 upd over rd shift", 64'(got), 64'(exp_upd));
    do_op(0, 0, 0, 1, '0);
    shift_out(got);
    chk("R9 upd over rd update", 64'(got), 64'(exp_upd));
    // R9: trigger beats capture; sr keeps shifted data
    shift_in(39'h05_0505_0505);
    do_op(1, 1, 0, 0, 5'b00100);
    wait_idle();
    chk("R9 trig over cap status", 64'(reconf_status), 64'h4);
    shift_out(got);
    chk("R9 trig over cap shift", 64'(got), 64'h05_0505_0505);
    exp_ctrl = exp_upd;

    // R7: request while busy ignored
    shift_in(39'h66_0000_0066);
    do_op(1, 0, 0, 0, 5'b00001);
    chk("R7 busy high", 64'(busy), 64'h1);
    do_op(0, 0, 1, 0, '0);
    wait_idle();
    chk_ctrl("R7 ctrl after trig", exp_upd);
    do_op(0, 0, 0, 1, '0);
    shift_out(got);
    chk("R7 update untouched", 64'(got), 64'(exp_upd));

    // R10: lowest set cause bit recorded
    do_op(1, 0, 0, 0, 5'b11000);
    wait_idle();
    chk("R10 cause 11000", 64'(reconf_status), 64'h08);
    do_op(1, 0, 0, 0, 5'b10110);
    wait_idle();
    chk("R10 cause 10110", 64'(reconf_status), 64'h02);

    summary();
    $finish;
  end
endmodule